// File: doc/BRIEF.md
# Bus Lock Translator for a Packet-to-Parallel Bridge

This block sits on the parallel-bus side of a bridge from a packet interconnect to an older parallel bus. It takes decoded request descriptors (plain read, locked read, write), each with an owner tag, an address and write data. It runs each request as one simple master cycle on the parallel bus. That cycle is an address phase with the frame line low, then a data phase that waits for target ready. Read data comes back as a completion.

A locked read pulls the active-low bus lock line low from its own address phase. The lock line stays low through the read's completion and through any further reads and writes from the same owner. It returns high once the owner's write has finished its data phase. While the lock is held, requests from any other owner get a retry indication and no bus cycle is started. If the owner goes quiet for a programmable number of idle cycles, the lock is dropped anyway and a one-cycle timeout flag is raised, so the bus cannot deadlock.

Top module: `lockBridge`

## Requirements
- R1: A locked read (reqKind 1) accepted while no lock is held produces an address phase in the next cycle, with busFrameN low, busLockN low, busCbeN = 4'b0110 (memory read) and busAd = request address.
- R2: busLockN is active low. It is high after reset, and a plain read (reqKind 0) or write (reqKind 2) issued while no lock is held leaves it high throughout.
- R3: In the data phase busFrameN is high and busCbeN is 4'b0000 (all byte lanes enabled). The cycle after busTrdyN is sampled low, cplValid is high for one cycle and cplData holds the busRdData seen at that edge. A held lock stays asserted past the completion.
- R4: Reads and writes from the lock owner are accepted (reqReady high) and run on the bus with busLockN kept low. A write uses busCbeN = 4'b0111 in its address phase and puts its data on busAd in the data phase.
- R5: A write from the owner releases the lock. busLockN is high from the cycle after that write's data phase sees busTrdyN low, and stays low until then.
- R6: While the lock is held and the block is idle, a request whose reqOwner differs from the owner gets reqRetry high and reqReady low, and no address phase follows.
- R7: When the lock is held with no request accepted for timeoutLimit consecutive idle cycles, busLockN goes high and lockTimeout pulses high for one cycle. After that, other owners are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request descriptor present |
| reqKind | input | 2 | 0 read, 1 locked read, 2 write |
| reqOwner | input | OWNER_W | Requester tag |
| reqAddr | input | BUS_W | Request address |
| reqData | input | BUS_W | Write data |
| timeoutLimit | input | TIMER_W | Idle cycles allowed while locked |
| reqReady | output | 1 | Request accepted this cycle |
| reqRetry | output | 1 | Request refused, retry later |
| busFrameN | output | 1 | Active-low frame, low in address phase |
| busLockN | output | 1 | Active-low bus lock |
| busCbeN | output | 4 | Command / active-low byte enables |
| busAd | output | BUS_W | Address or write data driven to bus |
| busTrdyN | input | 1 | Active-low target ready |
| busRdData | input | BUS_W | Read data from target |
| cplValid | output | 1 | Completion valid pulse |
| cplData | output | BUS_W | Completion read data |
| lockTimeout | output | 1 | Lock dropped by timeout (pulse) |

## Verification
The assertions assume that busTrdyN is only pulled low by the target during a data phase. They also assume that reqKind never carries the unused code 3 and that timeoutLimit is held steady while a lock is up. The bench drives busTrdyN low for exactly one data-phase cycle per transaction and releases it on the next falling edge. It only sends the three defined kinds, and it changes timeoutLimit only while no lock is held. Wait states before target ready vary between transactions, so that completion and release timing is seen over more than one data-phase length.

// File: rtl/lockBridgePkg.sv
package lockBridgePkg;
  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_LOCKRD = 2'd1,
    KIND_WRITE  = 2'd2
  } reqKindT;

  localparam logic [3:0] CMD_MEMRD = 4'b0110;
  localparam logic [3:0] CMD_MEMWR = 4'b0111;
  localparam logic [3:0] BE_ALL_ON = 4'b0000;
  localparam logic [3:0] CBE_IDLE  = 4'b1111;

  typedef struct packed {
    logic loadReq;
    logic addrPhase;
    logic dataPhase;
    logic finish;
  } strobeT;
endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import lockBridgePkg::*;
#(
  parameter int OWNER_W = 4,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [OWNER_W-1:0] reqOwner,
  input  logic [TIMER_W-1:0] timeoutLimit,
  input  logic               busTrdyN,
  output logic               reqReady,
  output logic               reqRetry,
  output logic               busFrameN,
  output logic               busLockN,
  output logic               lockTimeout,
  output strobeT             strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} stateT;

  stateT              state;
  logic               lockHeld;
  logic [OWNER_W-1:0] ownerId;
  logic [TIMER_W-1:0] idleCnt;
  logic               curIsWrite;
  logic               idleNow;
  logic               refuse;
  logic               accept;
  logic [TIMER_W:0]   cntNext;

  always_comb begin
    idleNow  = (state == ST_IDLE);
    refuse   = lockHeld && (reqOwner != ownerId);
    accept   = idleNow && reqValid && !refuse;
    reqReady = accept;
    reqRetry = idleNow && reqValid && refuse;
    cntNext  = {1'b0, idleCnt} + 1'b1;
    strobe.loadReq   = accept;
    strobe.addrPhase = (state == ST_ADDR);
    strobe.dataPhase = (state == ST_DATA);
    strobe.finish    = (state == ST_DATA) && !busTrdyN;
    busFrameN = !(state == ST_ADDR);
    busLockN  = !lockHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      lockHeld    <= 1'b0;
      ownerId     <= '0;
      idleCnt     <= '0;
      curIsWrite  <= 1'b0;
      lockTimeout <= 1'b0;
    end else begin
      lockTimeout <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_ADDR;
            idleCnt    <= '0;
            curIsWrite <= (reqKind == KIND_WRITE);
            if (reqKind == KIND_LOCKRD && !lockHeld) begin
              lockHeld <= 1'b1;
              ownerId  <= reqOwner;
            end
          end else if (lockHeld) begin
            if (cntNext >= {1'b0, timeoutLimit}) begin
              lockHeld    <= 1'b0;
              lockTimeout <= 1'b1;
              idleCnt     <= '0;
            end else begin
              idleCnt <= cntNext[TIMER_W-1:0];
            end
          end else begin
            idleCnt <= '0;
          end
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: begin
          if (!busTrdyN) begin
            state <= ST_IDLE;
            if (curIsWrite && lockHeld) lockHeld <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lockDatapath.sv
module lockDatapath
  import lockBridgePkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [1:0]       reqKind,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqData,
  input  logic [BUS_W-1:0] busRdData,
  output logic [3:0]       busCbeN,
  output logic [BUS_W-1:0] busAd,
  output logic             cplValid,
  output logic [BUS_W-1:0] cplData
);
  logic [BUS_W-1:0] addrQ;
  logic [BUS_W-1:0] dataQ;
  logic             isWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      isWrQ    <= 1'b0;
      cplValid <= 1'b0;
      cplData  <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        isWrQ <= (reqKind == KIND_WRITE);
      end
      cplValid <= strobe.finish && !isWrQ;
      if (strobe.finish && !isWrQ) cplData <= busRdData;
    end
  end

  always_comb begin
    if (strobe.addrPhase) begin
      busCbeN = isWrQ ? CMD_MEMWR : CMD_MEMRD;
      busAd   = addrQ;
    end else if (strobe.dataPhase) begin
      busCbeN = BE_ALL_ON;
      busAd   = isWrQ ? dataQ : '0;
    end else begin
      busCbeN = CBE_IDLE;
      busAd   = '0;
    end
  end
endmodule

// File: rtl/lockBridge.sv
module lockBridge
  import lockBridgePkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int OWNER_W = 4,
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [OWNER_W-1:0] reqOwner,
  input  logic [BUS_W-1:0]   reqAddr,
  input  logic [BUS_W-1:0]   reqData,
  input  logic [TIMER_W-1:0] timeoutLimit,
  output logic               reqReady,
  output logic               reqRetry,
  output logic               busFrameN,
  output logic               busLockN,
  output logic [3:0]         busCbeN,
  output logic [BUS_W-1:0]   busAd,
  input  logic               busTrdyN,
  input  logic [BUS_W-1:0]   busRdData,
  output logic               cplValid,
  output logic [BUS_W-1:0]   cplData,
  output logic               lockTimeout
);
  strobeT strobe;

  lockCtrl #(.OWNER_W(OWNER_W), .TIMER_W(TIMER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqOwner(reqOwner), .timeoutLimit(timeoutLimit), .busTrdyN(busTrdyN),
    .reqReady(reqReady), .reqRetry(reqRetry), .busFrameN(busFrameN),
    .busLockN(busLockN), .lockTimeout(lockTimeout), .strobe(strobe)
  );

  lockDatapath #(.BUS_W(BUS_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .busRdData(busRdData),
    .busCbeN(busCbeN), .busAd(busAd), .cplValid(cplValid), .cplData(cplData)
  );
endmodule

// File: rtl/lockBridgeChk.sv
module lockBridgeChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       reqRetry,
  input logic       busFrameN,
  input logic       busLockN,
  input logic [3:0] busCbeN,
  input logic       busTrdyN,
  input logic       cplValid,
  input logic       lockTimeout
);
  // R1
  lock_with_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busLockN) |-> (!busFrameN && busCbeN == 4'b0110));

  // R5
  release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLockN) |-> ($past(!busTrdyN) || lockTimeout));

  // R3
  cpl_after_trdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> $past(!busTrdyN));

  // R6
  retry_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqRetry |-> (!reqReady && !busLockN));

  // R6
  retry_no_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqRetry && busFrameN) |=> busFrameN);

  // R7
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockTimeout |-> (busLockN && $past(!busLockN)));

  // R3
  single_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busFrameN |=> busFrameN);
endmodule

bind lockBridge lockBridgeChk uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .reqRetry(reqRetry),
  .busFrameN(busFrameN), .busLockN(busLockN), .busCbeN(busCbeN),
  .busTrdyN(busTrdyN), .cplValid(cplValid), .lockTimeout(lockTimeout)
);

// File: tb/sim_lockBridge.sv
module sim_lockBridge;
  localparam int BUS_W   = 32;
  localparam int OWNER_W = 4;
  localparam int TIMER_W = 16;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  owner;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  waits;
    logic        lockDuring;
    logic        lockAfter;
  } vecT;

  localparam int NV = 8;
  localparam vecT VECS [NV] = '{
    '{2'd0, 4'd2, 32'h0000_1000, 32'h0,         32'hA5A5_0001, 4'd0, 1'b0, 1'b0},
    '{2'd2, 4'd3, 32'h0000_1004, 32'h1234_5678, 32'h0,         4'd1, 1'b0, 1'b0},
    '{2'd1, 4'd1, 32'h0000_2000, 32'h0,         32'hDEAD_BEEF, 4'd2, 1'b1, 1'b1},
    '{2'd0, 4'd1, 32'h0000_2004, 32'h0,         32'h0BAD_F00D, 4'd0, 1'b1, 1'b1},
    '{2'd2, 4'd1, 32'h0000_2000, 32'hCAFE_0002, 32'h0,         4'd3, 1'b1, 1'b0},
    '{2'd0, 4'd7, 32'h0000_3000, 32'h0,         32'h7777_0007, 4'd1, 1'b0, 1'b0},
    '{2'd1, 4'd6, 32'h0000_4000, 32'h0,         32'h6666_1111, 4'd0, 1'b1, 1'b1},
    '{2'd2, 4'd6, 32'h0000_4000, 32'h6666_2222, 32'h0,         4'd0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [OWNER_W-1:0] reqOwner = '0;
  logic [BUS_W-1:0] reqAddr = '0;
  logic [BUS_W-1:0] reqData = '0;
  logic [TIMER_W-1:0] timeoutLimit = 16'd1000;
  logic busTrdyN = 1'b1;
  logic [BUS_W-1:0] busRdData = '0;
  logic reqReady, reqRetry, busFrameN, busLockN, cplValid, lockTimeout;
  logic [3:0] busCbeN;
  logic [BUS_W-1:0] busAd, cplData;

  int checks = 0;
  int errors = 0;
  logic toSeen = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  lockBridge #(.BUS_W(BUS_W), .OWNER_W(OWNER_W), .TIMER_W(TIMER_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqOwner(reqOwner), .reqAddr(reqAddr), .reqData(reqData),
    .timeoutLimit(timeoutLimit), .reqReady(reqReady), .reqRetry(reqRetry),
    .busFrameN(busFrameN), .busLockN(busLockN), .busCbeN(busCbeN),
    .busAd(busAd), .busTrdyN(busTrdyN), .busRdData(busRdData),
    .cplValid(cplValid), .cplData(cplData), .lockTimeout(lockTimeout)
  );

  always @(negedge clk) if (lockTimeout) toSeen = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runVec(input vecT v);
    logic isWr;
    isWr = (v.kind == 2'd2);
    @(negedge clk);
    reqValid = 1'b1; reqKind = v.kind; reqOwner = v.owner;
    reqAddr = v.addr; reqData = v.wdata;
    #1;
    chk("R4 accepted", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 frame low in address phase", {31'd0, busFrameN}, 32'd0);
    chk("R1/R4 command", {28'd0, busCbeN}, isWr ? 32'h7 : 32'h6);
    chk("R1 address on bus", busAd, v.addr);
    chk("R2/R4 lock during address phase", {31'd0, busLockN}, {31'd0, !v.lockDuring});
    @(negedge clk);
    chk("R3 frame high in data phase", {31'd0, busFrameN}, 32'd1);
    chk("R3 byte enables", {28'd0, busCbeN}, 32'h0);
    if (isWr) chk("R4 write data on bus", busAd, v.wdata);
    for (int i = 0; i < int'(v.waits); i++) begin
      @(negedge clk);
      chk("R3 no completion before ready", {31'd0, cplValid}, 32'd0);
    end
    busTrdyN = 1'b0; busRdData = v.rdata;
    @(negedge clk);
    busTrdyN = 1'b1; busRdData = '0;
    chk("R3 completion pulse", {31'd0, cplValid}, {31'd0, !isWr});
    if (!isWr) chk("R3 completion data", cplData, v.rdata);
    chk("R5/R3 lock after transaction", {31'd0, busLockN}, {31'd0, !v.lockAfter});
    @(negedge clk);
    chk("R3 completion one cycle", {31'd0, cplValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset lock high", {31'd0, busLockN}, 32'd1);
    chk("R2 reset frame high", {31'd0, busFrameN}, 32'd1);
    chk("R3 reset no completion", {31'd0, cplValid}, 32'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R6 refusal while owner 1 holds the lock
    runVec('{2'd1, 4'd1, 32'h0000_5000, 32'h0, 32'h5151_5151, 4'd0, 1'b1, 1'b1});
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqOwner = 4'd9; reqAddr = 32'h0000_5004;
    #1;
    chk("R6 retry raised", {31'd0, reqRetry}, 32'd1);
    chk("R6 not accepted", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 no address phase", {31'd0, busFrameN}, 32'd1);
    chk("R6 lock kept", {31'd0, busLockN}, 32'd0);
    runVec('{2'd2, 4'd1, 32'h0000_5000, 32'h0000_00AA, 32'h0, 4'd2, 1'b1, 1'b0});

    // R7 timeout
    timeoutLimit = 16'd8;
    runVec('{2'd1, 4'd4, 32'h0000_6000, 32'h0, 32'h4444_4444, 4'd0, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    chk("R7 lock held before limit", {31'd0, busLockN}, 32'd0);
    chk("R7 no early timeout", {31'd0, toSeen}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R7 lock dropped", {31'd0, busLockN}, 32'd1);
    chk("R7 timeout flag", {31'd0, toSeen}, 32'd1);
    timeoutLimit = 16'd1000;
    runVec('{2'd0, 4'd8, 32'h0000_7000, 32'h0, 32'h8888_0000, 4'd0, 1'b0, 1'b0});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule